// File: doc/BRIEF.md
# Debug Address Break Controller

The block watches every processor bus cycle and compares it against up to two programmed break conditions. Each channel holds a break address, a per-bit ignore mask, an access-type condition and a filter on which bus master may trigger it. When a cycle satisfies a channel, that channel's sticky match flag is set. If the channel's request enable is on, a break request goes to the core at the right instruction boundary. A fetch match is held until the core begins executing the fetched instruction, and is dropped if the fetch is flushed first. A data match is held until the instruction that made the access completes.

Software programs the channels through a simple write port. Each write selects a channel and one of four registers: 0 is the break address, 1 is the ignore mask, 2 is control, and 3 clears the flag. In the control register, bits [1:0] hold the condition, bit 2 admits the DMA master and bit 3 enables the request. A module-stop input parks the whole compare path, so a stopped block stays silent. The core turns `brk_req` into an exception; vectoring is handled elsewhere.

Each channel runs a three-state sequencer:

- CH_IDLE goes to CH_FETCH_PEND on a fetch hit, or to CH_DATA_PEND on a data hit.
- CH_FETCH_PEND goes back to CH_IDLE on `exec_start` (this is where it fires) or on `fetch_flush` (this discards the match).
- CH_DATA_PEND goes back to CH_IDLE on `insn_end`, which is where it fires.
- Module stop forces every channel to CH_IDLE.

Top module: `addr_break_ctrl`

## Requirements
- R1: After reset both match flags read 0 and `brk_req` is 0. The reset configuration is: address 0, mask 0, fetch condition, CPU only, request disabled.
- R2: A channel's address test passes when `((bus_addr ^ break_addr) & ~mask) == 0` over all 24 bits. A mask bit of 1 removes that bit from the test.
- R3: Access kinds on `bus_kind` are 0 fetch, 1 read and 2 write; 3 never matches. Condition codes are 0 fetch, 1 read, 2 write and 3 read-or-write, and a channel matches only kinds its condition admits.
- R4: With control bit 2 at 0, only CPU cycles (`bus_dma`=0) match. With bit 2 at 1, both CPU and DMA cycles match.
- R5: A match sets that channel's flag on the next clock edge, and the flag stays set. A write to register 3 with data bit 0 = 0 clears the selected channel's flag; data bit 0 = 1 leaves it unchanged. A set in the same cycle as a clear wins. A clear touches no other channel.
- R6: After a fetch match, `brk_req` rises combinationally in the first later cycle with `exec_start` high, not before. It fires once per match.
- R7: `fetch_flush` while a fetch match is pending discards it. A later `exec_start` raises no request, and a flush in the same cycle as `exec_start` wins.
- R8: After a data match, `brk_req` rises combinationally in the first later cycle with `insn_end` high.
- R9: With control bit 3 at 0, a match still sets the flag but never raises `brk_req`.
- R10: When both channels match the same cycle, both flags set and a single `brk_req` line is raised.
- R11: While `mstop` is 1, no cycle sets a flag, pending matches are discarded and `brk_req` stays 0.
- R12: A pending fetch match ignores `insn_end`, and a pending data match ignores `exec_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mstop | input | 1 | Module stop; parks all compares and requests |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W (1) | Channel selected for the write |
| cfg_reg | input | 2 | Register: 0 address, 1 mask, 2 control, 3 flag clear |
| cfg_wdata | input | ADDR_W (24) | Write data |
| bus_valid | input | 1 | A bus cycle is present |
| bus_addr | input | ADDR_W (24) | Bus cycle address |
| bus_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 none |
| bus_dma | input | 1 | 1 when the DMA controller owns the cycle |
| exec_start | input | 1 | Core begins executing the fetched instruction |
| fetch_flush | input | 1 | Fetched instruction discarded |
| insn_end | input | 1 | Current instruction completes |
| match_flag | output | N_CH (2) | Sticky per-channel match flags |
| brk_req | output | 1 | Break request to the core |

## Verification
The bench builds the block with its defaults: a 24-bit address and two channels. The 24-bit address lets masks reach the top byte as well as the low nibble. Two channels allow a coincident hit, and allow a check that clearing one flag leaves the other alone. A vector table covers the mask, condition and master-filter combinations. Directed sequences cover the boundary timing of each pending state, flushes, request gating and module stop.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        COND_FETCH = 2'd0,
        COND_READ  = 2'd1,
        COND_WRITE = 2'd2,
        COND_RW    = 2'd3
    } cond_t;

    typedef enum logic [1:0] {
        CH_IDLE       = 2'd0,
        CH_FETCH_PEND = 2'd1,
        CH_DATA_PEND  = 2'd2
    } ch_state_t;

    typedef struct packed {
        logic  ie;
        logic  dma_ok;
        cond_t cond;
    } ctrl_t;

    localparam logic [1:0] REG_ADDR = 2'd0;
    localparam logic [1:0] REG_MASK = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
    localparam logic [1:0] REG_FCLR = 2'd3;

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int N_CH   = 2,
    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [SEL_W-1:0]               cfg_sel,
    input  logic [1:0]                     cfg_reg,
    input  logic [ADDR_W-1:0]              cfg_wdata,
    input  logic [N_CH-1:0]                set_vec,
    output logic [N_CH-1:0][ADDR_W-1:0]    addr_q,
    output logic [N_CH-1:0][ADDR_W-1:0]    mask_q,
    output ctrl_t [N_CH-1:0]               ctrl_q,
    output logic [N_CH-1:0]                flag_q
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        logic hit_sel;
        logic clr_req;

        assign hit_sel = cfg_we && (cfg_sel == IDX);
        assign clr_req = hit_sel && (cfg_reg == REG_FCLR) && !cfg_wdata[0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[i] <= '0;
                mask_q[i] <= '0;
                ctrl_q[i] <= '{ie: 1'b0, dma_ok: 1'b0, cond: COND_FETCH};
            end else if (hit_sel) begin
                unique case (cfg_reg)
                    REG_ADDR: addr_q[i] <= cfg_wdata;
                    REG_MASK: mask_q[i] <= cfg_wdata;
                    REG_CTRL: ctrl_q[i] <= '{ie:     cfg_wdata[3],
                                             dma_ok: cfg_wdata[2],
                                             cond:   cond_t'(cfg_wdata[1:0])};
                    default:  ;
                endcase
            end
        end

        // Set has priority over a software clear in the same cycle.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_req) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] brk_mask,
    input  ctrl_t             ctrl,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_dma,
    output logic              hit_fetch,
    output logic              hit_data
);

    acc_kind_t kind;
    logic      addr_ok;
    logic      kind_ok;
    logic      master_ok;
    logic      hit;

    assign kind      = acc_kind_t'(bus_kind);
    assign addr_ok   = ((bus_addr ^ brk_addr) & ~brk_mask) == '0;
    assign master_ok = !bus_dma || ctrl.dma_ok;

    always_comb begin
        unique case (ctrl.cond)
            COND_FETCH: kind_ok = (kind == KIND_FETCH);
            COND_READ:  kind_ok = (kind == KIND_READ);
            COND_WRITE: kind_ok = (kind == KIND_WRITE);
            COND_RW:    kind_ok = (kind == KIND_READ) || (kind == KIND_WRITE);
            default:    kind_ok = 1'b0;
        endcase
    end

    assign hit       = en && bus_valid && addr_ok && kind_ok && master_ok;
    assign hit_fetch = hit && (kind == KIND_FETCH);
    assign hit_data  = hit && (kind != KIND_FETCH);

endmodule

// File: rtl/brk_chan_fsm.sv
module brk_chan_fsm
    import brk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      mstop,
    input  logic      hit_fetch,
    input  logic      hit_data,
    input  logic      exec_start,
    input  logic      fetch_flush,
    input  logic      insn_end,
    input  logic      ie,
    output logic      fire,
    output ch_state_t state
);

    ch_state_t state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        if (mstop) begin
            state_nx = CH_IDLE;
        end else begin
            unique case (state)
                CH_IDLE: begin
                    if (hit_fetch) begin
                        state_nx = CH_FETCH_PEND;
                    end else if (hit_data) begin
                        state_nx = CH_DATA_PEND;
                    end
                end
                CH_FETCH_PEND: begin
                    if (fetch_flush || exec_start) begin
                        state_nx = CH_IDLE;
                    end
                end
                CH_DATA_PEND: begin
                    if (insn_end) begin
                        state_nx = CH_IDLE;
                    end
                end
                default: state_nx = CH_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        if (!mstop && ie) begin
            unique case (state)
                CH_FETCH_PEND: fire = exec_start && !fetch_flush;
                CH_DATA_PEND:  fire = insn_end;
                default:       fire = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/addr_break_ctrl.sv
module addr_break_ctrl
    import brk_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int N_CH   = 2,
    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mstop,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [1:0]        cfg_reg,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_kind,
    input  logic              bus_dma,
    input  logic              exec_start,
    input  logic              fetch_flush,
    input  logic              insn_end,
    output logic [N_CH-1:0]   match_flag,
    output logic              brk_req
);

    logic [N_CH-1:0][ADDR_W-1:0] addr_q;
    logic [N_CH-1:0][ADDR_W-1:0] mask_q;
    ctrl_t [N_CH-1:0]            ctrl_q;
    logic [N_CH-1:0]             flag_q;
    logic [N_CH-1:0]             set_vec;
    logic [N_CH-1:0]             fire_vec;
    logic [N_CH-1:0]             ie_vec;

    brk_cfg_regs #(
        .ADDR_W (ADDR_W),
        .N_CH   (N_CH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_reg   (cfg_reg),
        .cfg_wdata (cfg_wdata),
        .set_vec   (set_vec),
        .addr_q    (addr_q),
        .mask_q    (mask_q),
        .ctrl_q    (ctrl_q),
        .flag_q    (flag_q)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic      hit_fetch;
        logic      hit_data;
        ch_state_t st;

        assign ie_vec[i] = ctrl_q[i].ie;

        brk_addr_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .en        (!mstop),
            .brk_addr  (addr_q[i]),
            .brk_mask  (mask_q[i]),
            .ctrl      (ctrl_q[i]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_kind  (bus_kind),
            .bus_dma   (bus_dma),
            .hit_fetch (hit_fetch),
            .hit_data  (hit_data)
        );

        assign set_vec[i] = hit_fetch || hit_data;

        brk_chan_fsm u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .mstop       (mstop),
            .hit_fetch   (hit_fetch),
            .hit_data    (hit_data),
            .exec_start  (exec_start),
            .fetch_flush (fetch_flush),
            .insn_end    (insn_end),
            .ie          (ie_vec[i]),
            .fire        (fire_vec[i]),
            .state       (st)
        );
    end

    assign match_flag = flag_q;
    assign brk_req    = |fire_vec;

endmodule

// File: rtl/brk_checker.sv
module brk_checker #(
    parameter int N_CH   = 2,
    parameter int SEL_W  = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mstop,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_sel,
    input logic [1:0]       cfg_reg,
    input logic             cfg_wd0,
    input logic             exec_start,
    input logic             fetch_flush,
    input logic             insn_end,
    input logic [N_CH-1:0]  match_flag,
    input logic [N_CH-1:0]  ie_vec,
    input logic             brk_req
);

    AST_REQ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (exec_start || insn_end)); // R6

    AST_FLUSH_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_flush && !insn_end) |-> !brk_req); // R7

    AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (|ie_vec)); // R9

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        mstop |-> !brk_req); // R11

    AST_STOP_NO_NEW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mstop && match_flag == '0) |=> (match_flag == '0)); // R11

    for (genvar i = 0; i < N_CH; i++) begin : g_flag
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (match_flag[i] && !(cfg_we && cfg_sel == IDX && cfg_reg == 2'd3 && !cfg_wd0))
            |=> match_flag[i]); // R5
    end

endmodule

bind addr_break_ctrl brk_checker #(
    .N_CH  (N_CH),
    .SEL_W (SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mstop       (mstop),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_reg     (cfg_reg),
    .cfg_wd0     (cfg_wdata[0]),
    .exec_start  (exec_start),
    .fetch_flush (fetch_flush),
    .insn_end    (insn_end),
    .match_flag  (match_flag),
    .ie_vec      (ie_vec),
    .brk_req     (brk_req)
);

// File: tb/addr_break_ctrl_test.sv
module addr_break_ctrl_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mstop = 1'b0;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_sel = '0;
    logic [1:0]  cfg_reg = '0;
    logic [23:0] cfg_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [1:0]  bus_kind = '0;
    logic        bus_dma = 1'b0;
    logic        exec_start = 1'b0;
    logic        fetch_flush = 1'b0;
    logic        insn_end = 1'b0;
    logic [1:0]  match_flag;
    logic        brk_req;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    addr_break_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mstop(mstop),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_reg(cfg_reg), .cfg_wdata(cfg_wdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind), .bus_dma(bus_dma),
        .exec_start(exec_start), .fetch_flush(fetch_flush), .insn_end(insn_end),
        .match_flag(match_flag), .brk_req(brk_req)
    );

    typedef struct packed {
        logic [23:0] ba;
        logic [23:0] bm;
        logic [1:0]  cond;
        logic        dok;
        logic [23:0] a;
        logic [1:0]  k;
        logic        d;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // Kinds: 0 fetch, 1 read, 2 write, 3 none. Conditions: 0 F, 1 R, 2 W, 3 RW.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{24'h123456, 24'h000000, 2'd0, 1'b0, 24'h123456, 2'd0, 1'b0, 1'b1, 4'd2}, // R2 exact
        '{24'h123456, 24'h000000, 2'd0, 1'b0, 24'h123457, 2'd0, 1'b0, 1'b0, 4'd2}, // R2 bit 0 differs
        '{24'h123456, 24'h00000F, 2'd0, 1'b0, 24'h12345A, 2'd0, 1'b0, 1'b1, 4'd2}, // R2 masked nibble
        '{24'h123456, 24'h00000F, 2'd0, 1'b0, 24'h12355A, 2'd0, 1'b0, 1'b0, 4'd2}, // R2 bit 8 unmasked
        '{24'h123456, 24'hFF0000, 2'd0, 1'b0, 24'hAB3456, 2'd0, 1'b0, 1'b1, 4'd2}, // R2 top byte masked
        '{24'h123456, 24'h000000, 2'd0, 1'b0, 24'h923456, 2'd0, 1'b0, 1'b0, 4'd2}, // R2 bit 23 differs
        '{24'h004000, 24'h000000, 2'd1, 1'b0, 24'h004000, 2'd1, 1'b0, 1'b1, 4'd3}, // R3 read/read
        '{24'h004000, 24'h000000, 2'd1, 1'b0, 24'h004000, 2'd2, 1'b0, 1'b0, 4'd3}, // R3 read/write
        '{24'h004000, 24'h000000, 2'd2, 1'b0, 24'h004000, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 write/fetch
        '{24'h004000, 24'h000000, 2'd3, 1'b0, 24'h004000, 2'd2, 1'b0, 1'b1, 4'd3}, // R3 rw/write
        '{24'h004000, 24'h000000, 2'd3, 1'b0, 24'h004000, 2'd1, 1'b0, 1'b1, 4'd3}, // R3 rw/read
        '{24'h004000, 24'h000000, 2'd3, 1'b0, 24'h004000, 2'd0, 1'b0, 1'b0, 4'd3}, // R3 rw/fetch
        '{24'h004000, 24'h000000, 2'd3, 1'b0, 24'h004000, 2'd3, 1'b0, 1'b0, 4'd3}, // R3 kind none
        '{24'h004000, 24'h000000, 2'd1, 1'b0, 24'h004000, 2'd1, 1'b1, 1'b0, 4'd4}, // R4 CPU only, DMA cycle
        '{24'h004000, 24'h000000, 2'd1, 1'b1, 24'h004000, 2'd1, 1'b1, 1'b1, 4'd4}  // R4 DMA admitted
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic ch, input logic [1:0] rg, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = ch; cfg_reg = rg; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_chan(input logic ch, input logic [23:0] a, input logic [23:0] m,
                            input logic [1:0] cond, input logic dok, input logic ie);
        cfg_write(ch, 2'd3, 24'h0);
        cfg_write(ch, 2'd0, a);
        cfg_write(ch, 2'd1, m);
        cfg_write(ch, 2'd2, {20'h0, ie, dok, cond});
    endtask

    task automatic bus_cycle(input logic [23:0] a, input logic [1:0] k, input logic d);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_kind = k; bus_dma = d;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Drive strobes for one cycle; check the combinational request mid-cycle.
    task automatic strobe(input logic es, input logic fl, input logic ie_end,
                          input logic exp, input string req);
        @(negedge clk);
        exec_start = es; fetch_flush = fl; insn_end = ie_end;
        #1;
        check(req, 32'(brk_req), 32'(exp));
        @(negedge clk);
        exec_start = 1'b0; fetch_flush = 1'b0; insn_end = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        fetch_flush = 1'b1; insn_end = 1'b1;
        @(negedge clk);
        fetch_flush = 1'b0; insn_end = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 flags", 32'(match_flag), 32'h0);
        check("R1 brk_req", 32'(brk_req), 32'h0);

        // Table: compare, condition and master filter (R2, R3, R4)
        for (int i = 0; i < NV; i++) begin
            set_chan(1'b0, VECS[i].ba, VECS[i].bm, VECS[i].cond, VECS[i].dok, 1'b0);
            bus_cycle(VECS[i].a, VECS[i].k, VECS[i].d);
            checks++;
            if (match_flag[0] !== VECS[i].exp) begin
                failures++;
                $display("FAIL R%0d vector %0d actual=%0b expected=%0b",
                         VECS[i].req, i, match_flag[0], VECS[i].exp);
            end
            settle();
        end

        // R6 / R12: fetch break timing
        set_chan(1'b0, 24'h001000, 24'h0, 2'd0, 1'b0, 1'b1);
        bus_cycle(24'h001000, 2'd0, 1'b0);
        check("R5 flag set", 32'(match_flag[0]), 32'h1);
        #1 check("R6 no req before exec", 32'(brk_req), 32'h0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0, "R12 insn_end ignored on fetch");
        strobe(1'b1, 1'b0, 1'b0, 1'b1, "R6 fire on exec_start");
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R6 fires once");

        // R7: flush discards, and flush beats exec_start
        bus_cycle(24'h001000, 2'd0, 1'b0);
        strobe(1'b0, 1'b1, 1'b0, 1'b0, "R7 flush");
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R7 exec after flush");
        bus_cycle(24'h001000, 2'd0, 1'b0);
        strobe(1'b1, 1'b1, 1'b0, 1'b0, "R7 flush with exec");
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R7 nothing left");

        // R8 / R12: data break timing
        set_chan(1'b0, 24'h002000, 24'h0, 2'd2, 1'b0, 1'b1);
        bus_cycle(24'h002000, 2'd2, 1'b0);
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R12 exec_start ignored on data");
        strobe(1'b0, 1'b0, 1'b1, 1'b1, "R8 fire on insn_end");
        strobe(1'b0, 1'b0, 1'b1, 1'b0, "R8 fires once");

        // R9: request disabled
        set_chan(1'b0, 24'h002000, 24'h0, 2'd2, 1'b0, 1'b0);
        bus_cycle(24'h002000, 2'd2, 1'b0);
        check("R9 flag still set", 32'(match_flag[0]), 32'h1);
        strobe(1'b0, 1'b0, 1'b1, 1'b0, "R9 no req");

        // R5: flag clear semantics
        set_chan(1'b1, 24'h003000, 24'h0, 2'd1, 1'b0, 1'b0);
        bus_cycle(24'h003000, 2'd1, 1'b0);
        settle();
        check("R5 both flags", 32'(match_flag), 32'h3);
        cfg_write(1'b0, 2'd3, 24'h000001);
        check("R5 write 1 keeps", 32'(match_flag), 32'h3);
        cfg_write(1'b0, 2'd3, 24'h000000);
        check("R5 clear A only", 32'(match_flag), 32'h2);
        cfg_write(1'b1, 2'd3, 24'h000000);
        check("R5 clear B", 32'(match_flag), 32'h0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_reg = 2'd3; cfg_wdata = 24'h0;
        bus_valid = 1'b1; bus_addr = 24'h003000; bus_kind = 2'd1; bus_dma = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; bus_valid = 1'b0;
        check("R5 set wins over clear", 32'(match_flag[1]), 32'h1);
        settle();

        // R10: both channels in one cycle
        set_chan(1'b0, 24'h005000, 24'h0, 2'd0, 1'b0, 1'b1);
        set_chan(1'b1, 24'h005000, 24'h0, 2'd0, 1'b0, 1'b1);
        bus_cycle(24'h005000, 2'd0, 1'b0);
        check("R10 both flags", 32'(match_flag), 32'h3);
        strobe(1'b1, 1'b0, 1'b0, 1'b1, "R10 single request");
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R10 request ends");

        // R11: module stop
        cfg_write(1'b0, 2'd3, 24'h0);
        cfg_write(1'b1, 2'd3, 24'h0);
        @(negedge clk); mstop = 1'b1;
        bus_cycle(24'h005000, 2'd0, 1'b0);
        check("R11 no flag while stopped", 32'(match_flag), 32'h0);
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R11 no req while stopped");
        @(negedge clk); mstop = 1'b0;
        bus_cycle(24'h005000, 2'd0, 1'b0);
        @(negedge clk); mstop = 1'b1;
        @(negedge clk); mstop = 1'b0;
        strobe(1'b1, 1'b0, 1'b0, 1'b0, "R11 pending discarded");

        summary();
        $finish;
    end

endmodule